// File: doc/BRIEF.md
# Dual Byte FIFO with Trigger Levels

This block sits between a host register interface and the shift engine of a serial bus master. It holds two byte queues of sixteen entries each. Outgoing bytes are written by the host and taken by the engine. Incoming bytes are pushed by the engine and read by the host. Both queues share one data address. A write there queues an outgoing byte, and a read there returns the oldest incoming byte.

A control byte sets a threshold for each queue and carries two one-shot flush bits. The receive threshold and the transmit threshold use different encodings. Sticky status flags report three conditions: enough received bytes are waiting, the outgoing queue has drained to its level, and the final outgoing byte has completely left the shifter. Software clears a flag by writing 0 to it. While the receive flag or the transmit-end flag is set, the block asks the bus engine to hold the clock low. The host can read the fill count of each queue. A per-flag enable byte gates a single request line.

Top module: `dual_fifo_port`

## Requirements
- R1: After reset both fill counts read 0, the control byte reads 0, and `scl_hold` and `irq_req` are low.
- R2: Bytes written to the data address (0) reach `eng_tx_data` in write order, one per `eng_tx_pop`. The transmit count (address 5) reports the bytes held, from 0 to 16. `eng_tx_valid` is high exactly when that count is non-zero.
- R3: A data write while 16 outgoing bytes are held is discarded. It sets the sticky overflow flag, status bit 3, and the queued contents are unchanged.
- R4: Bytes pushed by the engine with `eng_rx_push` come back in push order when the host reads the data address. The receive count (address 4) reports the bytes held.
- R5: A data read while the receive queue is empty returns 0 and leaves the receive count at 0.
- R6: Control bits 7:4 hold N. Status bit 1 sets once the receive count reaches N+1, and `scl_hold` is then high.
- R7: Control bits 3:2 select the transmit level: code 0 means at most 8 bytes held, 1 means at most 4, 2 means at most 2, and 3 means empty. Status bit 0 sets while the transmit count is at or below that level.
- R8: A write to status (address 2) clears each flag whose written bit is 0 and keeps each flag whose written bit is 1. Once cleared, a flag stays clear until its condition holds again. `scl_hold` is high exactly while status bit 1 or bit 2 is set.
- R9: Writing 1 to control bit 0 empties the transmit queue, and writing 1 to bit 1 empties the receive queue. Both bits read back as 0, and the threshold fields are stored from the same write.
- R10: Status bit 2 (transmit end) sets when `eng_tx_done` pulses while the transmit count is 0. A pulse while bytes remain queued leaves it clear.
- R11: `irq_req` is high when any of status bits 2:0 is set together with the matching bit of the enable byte (address 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops receive queue at data address) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational |
| eng_tx_pop | input | 1 | Engine takes the head outgoing byte |
| eng_tx_data | output | 8 | Head outgoing byte |
| eng_tx_valid | output | 1 | Outgoing queue not empty |
| eng_rx_push | input | 1 | Engine delivers an incoming byte |
| eng_rx_data | input | 8 | Incoming byte |
| eng_rx_full | output | 1 | Incoming queue full, push is dropped |
| eng_tx_done | input | 1 | Pulse: final bit of a byte has shifted out |
| scl_hold | output | 1 | Request to stretch the bus clock |
| irq_req | output | 1 | Enabled flag request |

## Verification
Some rules are checked by the assertions on every cycle. Counts stay within the queue depth. A write to a full transmit queue leaves the count unchanged and raises overflow. Either flush empties its queue on the next cycle. An empty read returns zero. Transmit end can only rise when the transmit count was zero, and a set receive flag survives any cycle without a status write. The scoreboard scenarios cover the rest: byte ordering through both queues, each of the four transmit level codes at its exact boundary, the receive threshold edge, the write-0-clears and write-1-keeps status semantics, and the enable gating of the request line.

// File: rtl/dfq_pkg.sv
package dfq_pkg;
  localparam logic [2:0] A_DATA  = 3'd0;
  localparam logic [2:0] A_CTRL  = 3'd1;
  localparam logic [2:0] A_STAT  = 3'd2;
  localparam logic [2:0] A_IEN   = 3'd3;
  localparam logic [2:0] A_RXCNT = 3'd4;
  localparam logic [2:0] A_TXCNT = 3'd5;

  // status bit positions
  localparam int S_TXLVL = 0;
  localparam int S_RXLVL = 1;
  localparam int S_TXEND = 2;
  localparam int S_OVF   = 3;

  // most bytes still queued for which the transmit level flag is raised
  function automatic int tx_room_limit(input logic [1:0] code);
    case (code)
      2'd0:    return 8;
      2'd1:    return 4;
      2'd2:    return 2;
      default: return 0;
    endcase
  endfunction

  // receive count that raises the receive level flag
  function automatic int rx_level(input logic [3:0] field);
    return int'(field) + 1;
  endfunction

  function automatic int ptr_next(input int p, input int depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction
endpackage

// File: rtl/dfq_byte_fifo.sv
module dfq_byte_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  import dfq_pkg::*;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  assign full    = (int'(count) == DEPTH);
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= AW'(ptr_next(int'(wr_ptr), DEPTH));
      if (do_pop)  rd_ptr <= AW'(ptr_next(int'(rd_ptr), DEPTH));
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/dfq_status.sv
module dfq_status #(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] tx_cnt,
  input  logic [CW-1:0] rx_cnt,
  input  logic [1:0]    tx_code,
  input  logic [3:0]    rx_field,
  input  logic          tx_done,
  input  logic          ovf_evt,
  input  logic          stat_wr,
  input  logic [3:0]    wmask,
  output logic [3:0]    flags
);
  import dfq_pkg::*;

  logic       cond_txlvl, cond_rxlvl, cond_txend;
  logic [3:0] keep, setv;

  assign cond_txlvl = int'(tx_cnt) <= tx_room_limit(tx_code);
  assign cond_rxlvl = int'(rx_cnt) >= rx_level(rx_field);
  assign cond_txend = tx_done && (tx_cnt == '0);

  always_comb begin
    keep = stat_wr ? wmask : 4'hF;
    setv = '0;
    setv[S_TXLVL] = cond_txlvl;
    setv[S_RXLVL] = cond_rxlvl;
    setv[S_TXEND] = cond_txend;
    setv[S_OVF]   = ovf_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & keep) | setv;
  end
endmodule

// File: rtl/dual_fifo_port.sv
module dual_fifo_port #(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    reg_addr,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  input  logic          eng_tx_pop,
  output logic [DW-1:0] eng_tx_data,
  output logic          eng_tx_valid,
  input  logic          eng_rx_push,
  input  logic [DW-1:0] eng_rx_data,
  output logic          eng_rx_full,
  input  logic          eng_tx_done,
  output logic          scl_hold,
  output logic          irq_req
);
  import dfq_pkg::*;
  localparam int CW = $clog2(DEPTH + 1);

  // named internal events
  logic          host_push, host_pop_req, ctrl_wr, stat_wr, ien_wr;
  logic          tx_clr, rx_clr, ovf_evt;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic          tx_full, tx_empty, rx_full, rx_empty;
  logic [DW-1:0] rx_head;
  logic [5:0]    ctrl_q;     // bits 7:2 of control byte
  logic [2:0]    ien_q;
  logic [3:0]    flags;

  assign host_push    = reg_wr && (reg_addr == A_DATA);
  assign host_pop_req = reg_rd && (reg_addr == A_DATA);
  assign ctrl_wr      = reg_wr && (reg_addr == A_CTRL);
  assign stat_wr      = reg_wr && (reg_addr == A_STAT);
  assign ien_wr       = reg_wr && (reg_addr == A_IEN);
  assign tx_clr       = ctrl_wr && reg_wdata[0];
  assign rx_clr       = ctrl_wr && reg_wdata[1];
  assign ovf_evt      = host_push && tx_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ien_q  <= '0;
    end else begin
      if (ctrl_wr) ctrl_q <= reg_wdata[7:2];
      if (ien_wr)  ien_q  <= reg_wdata[2:0];
    end
  end

  dfq_byte_fifo #(.DEPTH(DEPTH), .DW(DW)) u_txq (
    .clk(clk), .rst_n(rst_n), .clr(tx_clr),
    .push(host_push), .pop(eng_tx_pop), .din(reg_wdata[DW-1:0]),
    .dout(eng_tx_data), .count(tx_cnt), .full(tx_full), .empty(tx_empty)
  );

  dfq_byte_fifo #(.DEPTH(DEPTH), .DW(DW)) u_rxq (
    .clk(clk), .rst_n(rst_n), .clr(rx_clr),
    .push(eng_rx_push), .pop(host_pop_req), .din(eng_rx_data),
    .dout(rx_head), .count(rx_cnt), .full(rx_full), .empty(rx_empty)
  );

  dfq_status #(.DEPTH(DEPTH)) u_stat (
    .clk(clk), .rst_n(rst_n),
    .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
    .tx_code(ctrl_q[1:0]), .rx_field(ctrl_q[5:2]),
    .tx_done(eng_tx_done), .ovf_evt(ovf_evt),
    .stat_wr(stat_wr), .wmask(reg_wdata[3:0]),
    .flags(flags)
  );

  assign eng_tx_valid = !tx_empty;
  assign eng_rx_full  = rx_full;
  assign scl_hold     = flags[S_RXLVL] | flags[S_TXEND];
  assign irq_req      = |(flags[2:0] & ien_q);

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_DATA:  reg_rdata = rx_empty ? 8'h00 : 8'(rx_head);
      A_CTRL:  reg_rdata = {ctrl_q, 2'b00};
      A_STAT:  reg_rdata = {4'h0, flags};
      A_IEN:   reg_rdata = {5'h0, ien_q};
      A_RXCNT: reg_rdata = 8'(rx_cnt);
      A_TXCNT: reg_rdata = 8'(tx_cnt);
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/dfq_checker.sv
module dfq_checker #(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          host_push,
  input logic          host_pop_req,
  input logic          eng_tx_pop,
  input logic          stat_wr,
  input logic          tx_clr,
  input logic          rx_clr,
  input logic          tx_full,
  input logic          rx_empty,
  input logic [CW-1:0] tx_cnt,
  input logic [CW-1:0] rx_cnt,
  input logic [3:0]    flags,
  input logic [7:0]    reg_rdata
);
  // R2
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(tx_cnt) <= DEPTH) && (int'(rx_cnt) <= DEPTH));

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_push && tx_full && !eng_tx_pop && !tx_clr) |=> (int'(tx_cnt) == DEPTH));

  // R3
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_push && tx_full) |=> flags[3]);

  // R9
  tx_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_clr |=> (tx_cnt == '0));

  // R9
  rx_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_clr |=> (rx_cnt == '0));

  // R5
  empty_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_pop_req && rx_empty) |-> (reg_rdata == 8'h00));

  // R10
  txend_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[2]) |-> ($past(tx_cnt) == '0));

  // R8
  rxflag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[1] && !stat_wr) |=> flags[1]);
endmodule

bind dual_fifo_port dfq_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .host_push(host_push), .host_pop_req(host_pop_req),
  .eng_tx_pop(eng_tx_pop), .stat_wr(stat_wr),
  .tx_clr(tx_clr), .rx_clr(rx_clr),
  .tx_full(tx_full), .rx_empty(rx_empty),
  .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
  .flags(flags), .reg_rdata(reg_rdata)
);

// File: tb/dual_fifo_port_tb.sv
`timescale 1ns/100ps
module dual_fifo_port_tb;
  localparam int DEPTH = 16;

  logic       clk = 0, rst_n = 0;
  logic [2:0] reg_addr = 0;
  logic       reg_wr = 0, reg_rd = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic       eng_tx_pop = 0, eng_tx_valid, eng_rx_push = 0, eng_rx_full, eng_tx_done = 0;
  logic [7:0] eng_tx_data, eng_rx_data = 0;
  logic       scl_hold, irq_req;

  int tests = 0, fails = 0;
  bit finished = 0;
  logic [7:0] txq[$];
  logic [7:0] rxq[$];

  always #2.5 clk = ~clk;

  dual_fifo_port u_dut (.*);

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(posedge clk); #1 reg_wr = 0;
  endtask

  task automatic host_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1;
    #1 d = reg_rdata;
    @(posedge clk); #1 reg_rd = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  // driver: outgoing byte, expected only if model has room
  task automatic send(input logic [7:0] b);
    if (txq.size() < DEPTH) txq.push_back(b);
    host_wr(3'd0, b);
  endtask

  // monitor side: engine takes a byte and compares with scoreboard
  task automatic drain(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      logic [7:0] e;
      @(negedge clk);
      e = (txq.size() > 0) ? txq.pop_front() : 8'hxx;
      check(req, {7'd0, eng_tx_valid}, 8'd1);
      check(req, eng_tx_data, e);
      eng_tx_pop = 1;
      @(posedge clk); #1 eng_tx_pop = 0;
    end
  endtask

  task automatic deliver(input logic [7:0] b);
    rxq.push_back(b);
    @(negedge clk); eng_rx_data = b; eng_rx_push = 1;
    @(posedge clk); #1 eng_rx_push = 0;
  endtask

  task automatic collect(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      logic [7:0] d;
      logic [7:0] e;
      e = rxq.pop_front();
      host_rd(3'd0, d);
      check(req, d, e);
    end
  endtask

  task automatic done_pulse();
    @(negedge clk); eng_tx_done = 1;
    @(posedge clk); #1 eng_tx_done = 0;
  endtask

  task automatic stat_bit(input int b, input logic exp, input string req);
    logic [7:0] d;
    idle(2);
    host_rd(3'd2, d);
    check(req, {7'd0, d[b]}, {7'd0, exp});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int lim [4] = '{8, 4, 2, 0};
    idle(3); #1 rst_n = 1;

    // R1 reset state
    host_rd(3'd5, d); check("R1 txcnt", d, 0);
    host_rd(3'd4, d); check("R1 rxcnt", d, 0);
    host_rd(3'd1, d); check("R1 ctrl", d, 0);
    check("R1 scl_hold", {7'd0, scl_hold}, 0);
    check("R1 irq", {7'd0, irq_req}, 0);

    // R2 ordering
    for (int i = 0; i < 5; i++) send(8'hA0 + 8'(i));
    host_rd(3'd5, d); check("R2 txcnt", d, 5);
    drain(5, "R2 order");
    host_rd(3'd5, d); check("R2 txcnt empty", d, 0);
    check("R2 valid low", {7'd0, eng_tx_valid}, 0);

    // R3 overflow
    for (int i = 0; i < 17; i++) send(8'(i * 3 + 1));
    host_rd(3'd5, d); check("R3 full count", d, 16);
    stat_bit(3, 1'b1, "R3 ovf flag");
    drain(16, "R3 contents");
    check("R3 no extra", {7'd0, eng_tx_valid}, 0);
    host_wr(3'd2, 8'h00);
    stat_bit(3, 1'b0, "R8 ovf cleared");

    // R4 receive order
    deliver(8'h11); deliver(8'h22); deliver(8'h33);
    host_rd(3'd4, d); check("R4 rxcnt", d, 3);
    collect(3, "R4 order");

    // R5 empty read
    host_rd(3'd0, d); check("R5 empty data", d, 0);
    host_rd(3'd4, d); check("R5 rxcnt", d, 0);

    // R6 receive threshold N=3 -> 4 bytes
    host_wr(3'd1, 8'h30);
    host_wr(3'd2, 8'h00);
    deliver(8'h41); deliver(8'h42); deliver(8'h43);
    stat_bit(1, 1'b0, "R6 below level");
    check("R6 no hold", {7'd0, scl_hold}, 0);
    deliver(8'h44);
    stat_bit(1, 1'b1, "R6 at level");
    check("R6 hold", {7'd0, scl_hold}, 1);

    // R8 clear semantics
    collect(2, "R4 partial");
    host_wr(3'd2, 8'hFF);
    stat_bit(1, 1'b1, "R8 write1 keeps");
    host_wr(3'd2, 8'h00);
    stat_bit(1, 1'b0, "R8 write0 clears");
    check("R8 hold released", {7'd0, scl_hold}, 0);
    collect(2, "R4 rest");

    // R7 transmit level codes
    for (int c = 0; c < 4; c++) begin
      host_wr(3'd1, {4'h3, 2'(c), 2'b00});
      for (int i = 0; i <= lim[c]; i++) send(8'(c * 16 + i));
      host_wr(3'd2, 8'h00);
      stat_bit(0, 1'b0, $sformatf("R7 code%0d above", c));
      drain(1, "R7 drain");
      stat_bit(0, 1'b1, $sformatf("R7 code%0d at", c));
      drain(lim[c], "R7 drain");
    end

    // R9 flush bits
    for (int i = 0; i < 4; i++) send(8'h70 + 8'(i));
    deliver(8'h81); deliver(8'h82);
    host_wr(3'd1, 8'h31); txq.delete();
    host_rd(3'd5, d); check("R9 tx flushed", d, 0);
    host_rd(3'd4, d); check("R9 rx kept", d, 2);
    host_rd(3'd1, d); check("R9 ctrl readback", d, 8'h30);
    host_wr(3'd1, 8'h32); rxq.delete();
    host_rd(3'd4, d); check("R9 rx flushed", d, 0);
    send(8'h5A);
    drain(1, "R9 after flush");

    // R10 transmit end
    host_wr(3'd2, 8'h00);
    send(8'h66);
    done_pulse();
    stat_bit(2, 1'b0, "R10 not last");
    drain(1, "R10 drain");
    done_pulse();
    stat_bit(2, 1'b1, "R10 last");
    check("R10 hold", {7'd0, scl_hold}, 1);

    // R11 enable gating
    host_wr(3'd3, 8'h04);
    idle(1);
    check("R11 irq end", {7'd0, irq_req}, 1);
    host_wr(3'd2, 8'h00);
    idle(2);
    check("R11 irq off", {7'd0, irq_req}, 0);
    host_wr(3'd3, 8'h01);
    idle(1);
    check("R11 irq txlvl", {7'd0, irq_req}, 1);
    host_wr(3'd3, 8'h00);
    idle(1);
    check("R11 irq masked", {7'd0, irq_req}, 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule